// File: doc/BRIEF.md
# Show-Cycle Bus Interface Controller

This block decides what the external bus pins do while the processor runs a transfer that stays inside the chip. A two-bit mode input selects one of four behaviours. The block can keep the external address and data pins idle. It can copy each internal transfer onto those pins, with a strobe, so that an external analyser can capture it. The same mode input also decides whether an external master may be granted the bus.

An external master asks for the bus through a request line. When arbitration is allowed, the block issues the grant only in a cycle with no internal transfer in progress. It withdraws the grant one cycle after the request drops. While a grant is held, no transfer is copied out, because the pins belong to the other master. In one mode the block also raises a stall that holds internal activity for as long as the grant is held.

Top module: `show_bus_ctrl`

## Requirements
- R1: While rst_ni is low, and right after it is released, ext_gnt_o, int_stall_o, show_stb_o, ext_addr_oe_o and ext_data_oe_o are 0, and ext_addr_o and ext_data_o are all zeros. Asserting rst_ni while a grant is held drops ext_gnt_o at once.
- R2: With mode_i = 2'b00, no transfer is copied out: show_stb_o, both enables and both pin buses stay 0. Bus grants are still issued.
- R3: With mode_i = 2'b01, every transfer is copied out and ext_gnt_o is never 1. A request made in this mode is dropped rather than stored, so it produces no grant after a switch to a mode that allows arbitration.
- R4: With mode_i = 2'b10, transfers are copied out and grants are issued. While a grant is held, transfers continue without being copied out, and int_stall_o stays 0.
- R5: With mode_i = 2'b11, transfers are copied out, grants are issued, and int_stall_o equals ext_gnt_o in every cycle.
- R6: A transfer is copied out only in the same cycle that int_xfer_i is 1. In that cycle show_stb_o, ext_addr_oe_o and ext_data_oe_o are 1, ext_addr_o equals int_addr_i and ext_data_o equals int_data_i. In all other cycles the three strobes are 0 and the pin buses are zero.
- R7: ext_gnt_o becomes 1 only in the cycle after a clock edge at which ext_req_i was 1, int_xfer_i was 0, and arbitration was allowed. A request that arrives during a transfer waits until the transfer has ended.
- R8: Once granted, ext_gnt_o stays 1 while ext_req_i stays 1. It returns to 0 in the cycle after the first edge at which ext_req_i is 0.
- R9: In modes 2'b01, 2'b10 and 2'b11, no transfer is copied out in any cycle in which ext_gnt_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mode: 00 no copy/arbitration on, 01 copy/arbitration off, 10 copy/arbitration on, 11 copy/arbitration on with stall |
| int_xfer_i | input | 1 | Internal transfer in progress this cycle |
| int_addr_i | input | AW (16) | Address of the internal transfer |
| int_data_i | input | DW (16) | Data of the internal transfer |
| ext_req_i | input | 1 | External master bus request |
| ext_addr_o | output | AW (16) | External address pins |
| ext_data_o | output | DW (16) | External data pins |
| ext_addr_oe_o | output | 1 | External address drive enable |
| ext_data_oe_o | output | 1 | External data drive enable |
| show_stb_o | output | 1 | Marks a copied-out internal transfer |
| ext_gnt_o | output | 1 | Bus grant to the external master |
| int_stall_o | output | 1 | Holds internal activity |

## Verification
Two functions can fall in the same cycle: copying out a transfer and granting the bus. The bench provokes this by raising the request in the same cycle as a transfer. It expects the copy to take place and the grant to wait until the first edge with no transfer. A held grant is then met with a new transfer, which must go un-copied in mode 10 and comes with the stall in mode 11. A switch into mode 01 while a grant is held must remove the grant in that same cycle and let the transfer be copied out.

// File: rtl/show_bus_pkg.sv
package show_bus_pkg;

  typedef enum logic [1:0] {
    MODE_QUIET_ARB = 2'b00,
    MODE_SHOW_NOARB = 2'b01,
    MODE_SHOW_ARB  = 2'b10,
    MODE_SHOW_HALT = 2'b11
  } show_mode_e;

  typedef struct packed {
    logic show_en;
    logic arb_en;
    logic halt_en;
  } mode_ctl_t;

endpackage

// File: rtl/show_mode_dec.sv
module show_mode_dec
  import show_bus_pkg::*;
(
  input  logic [1:0] mode_i,
  output mode_ctl_t  ctl_o
);

  always_comb begin
    ctl_o = '0;
    unique case (show_mode_e'(mode_i))
      MODE_QUIET_ARB:  ctl_o = '{show_en: 1'b0, arb_en: 1'b1, halt_en: 1'b0};
      MODE_SHOW_NOARB: ctl_o = '{show_en: 1'b1, arb_en: 1'b0, halt_en: 1'b0};
      MODE_SHOW_ARB:   ctl_o = '{show_en: 1'b1, arb_en: 1'b1, halt_en: 1'b0};
      MODE_SHOW_HALT:  ctl_o = '{show_en: 1'b1, arb_en: 1'b1, halt_en: 1'b1};
      default:         ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/show_grant_arb.sv
module show_grant_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arb_en_i,
  input  logic req_i,
  input  logic xfer_i,
  output logic gnt_o
);

  logic gnt_q, gnt_d;

  // grant only between transfers; drop when request falls or arbitration is off
  always_comb begin
    gnt_d = gnt_q;
    if (!arb_en_i)             gnt_d = 1'b0;
    else if (gnt_q && !req_i)  gnt_d = 1'b0;
    else if (!gnt_q && req_i && !xfer_i) gnt_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= 1'b0;
    else         gnt_q <= gnt_d;
  end

  assign gnt_o = gnt_q & arb_en_i;

  // R7
  gnt_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_o && !(req_i && !xfer_i && arb_en_i)) |=> !gnt_o);

  // R8
  gnt_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o && !req_i) |=> !gnt_o);

endmodule

// File: rtl/show_mirror.sv
module show_mirror #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          show_en_i,
  input  logic          gnt_i,
  input  logic          xfer_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          addr_oe_o,
  output logic          data_oe_o,
  output logic          stb_o
);

  logic drive;

  assign drive     = show_en_i & xfer_i & ~gnt_i;
  assign stb_o     = drive;
  assign addr_oe_o = drive;
  assign data_oe_o = drive;
  assign addr_o    = drive ? addr_i : '0;
  assign data_o    = drive ? data_i : '0;

  // R6
  stb_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> (xfer_i && addr_o == addr_i && data_o == data_i));

  // R6
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |-> (!addr_oe_o && !data_oe_o && addr_o == '0 && data_o == '0));

endmodule

// File: rtl/show_bus_ctrl.sv
module show_bus_ctrl
  import show_bus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          int_xfer_i,
  input  logic [AW-1:0] int_addr_i,
  input  logic [DW-1:0] int_data_i,
  input  logic          ext_req_i,
  output logic [AW-1:0] ext_addr_o,
  output logic [DW-1:0] ext_data_o,
  output logic          ext_addr_oe_o,
  output logic          ext_data_oe_o,
  output logic          show_stb_o,
  output logic          ext_gnt_o,
  output logic          int_stall_o
);

  mode_ctl_t ctl;
  logic      gnt;

  show_mode_dec u_dec (
    .mode_i (mode_i),
    .ctl_o  (ctl)
  );

  show_grant_arb u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arb_en_i (ctl.arb_en),
    .req_i    (ext_req_i),
    .xfer_i   (int_xfer_i),
    .gnt_o    (gnt)
  );

  show_mirror #(.AW(AW), .DW(DW)) u_mir (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .show_en_i (ctl.show_en),
    .gnt_i     (gnt),
    .xfer_i    (int_xfer_i),
    .addr_i    (int_addr_i),
    .data_i    (int_data_i),
    .addr_o    (ext_addr_o),
    .data_o    (ext_data_o),
    .addr_oe_o (ext_addr_oe_o),
    .data_oe_o (ext_data_oe_o),
    .stb_o     (show_stb_o)
  );

  assign ext_gnt_o   = gnt;
  assign int_stall_o = ctl.halt_en & gnt;

  // R3
  no_arb_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01) |-> !ext_gnt_o);

  // R2
  quiet_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |-> (!show_stb_o && !ext_addr_oe_o && !ext_data_oe_o));

  // R9
  show_vs_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_gnt_o |-> !show_stb_o);

  // R5
  halt_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |-> (int_stall_o == ext_gnt_o));

  // R4
  stall_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b11) |-> !int_stall_o);

endmodule

// File: tb/show_bus_ctrl_test.sv
module show_bus_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NV = 21;

  // {mode[1:0], req, xfer, exp_show, exp_gnt, exp_stall}
  localparam logic [6:0] VEC [NV] = '{
    7'b00_0_1_000, // 0  R2 transfer not copied
    7'b00_1_1_000, // 1  R7 request during transfer waits
    7'b00_1_0_000, // 2  R7 grant taken at end of cycle
    7'b00_1_1_010, // 3  R2 grant allowed in quiet mode
    7'b00_0_0_010, // 4  R8 request drops
    7'b01_1_0_000, // 5  R8 released; R3 no grant
    7'b01_1_1_100, // 6  R3 copied
    7'b01_1_0_000, // 7  R6 idle
    7'b10_0_0_000, // 8  R3 not queued
    7'b10_1_1_100, // 9  R7 collision, copy wins
    7'b10_1_0_000, // 10 R7
    7'b10_1_1_010, // 11 R4 R9 transfer not copied under grant
    7'b11_1_0_011, // 12 R5 stall
    7'b11_0_0_011, // 13 R8
    7'b11_0_1_100, // 14 R5 R6
    7'b11_1_0_000, // 15 R7
    7'b11_1_0_011, // 16 R5
    7'b01_1_1_100, // 17 R3 grant dropped at once in 01
    7'b10_1_0_000, // 18 R3
    7'b10_0_0_010, // 19 R8
    7'b10_0_0_000  // 20 R8
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic          int_xfer_i = 1'b0;
  logic [AW-1:0] int_addr_i = '0;
  logic [DW-1:0] int_data_i = '0;
  logic          ext_req_i = 1'b0;
  logic [AW-1:0] ext_addr_o;
  logic [DW-1:0] ext_data_o;
  logic          ext_addr_oe_o, ext_data_oe_o, show_stb_o, ext_gnt_o, int_stall_o;

  int checks = 0;
  int errors = 0;
  string tag [NV];

  show_bus_ctrl #(.AW(AW), .DW(DW)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle_pins(input string req);
    check(req, "strobes", {show_stb_o, ext_addr_oe_o, ext_data_oe_o}, 32'd0);
    check(req, "pins", {ext_addr_o, ext_data_o}, 32'd0);
  endtask

  initial begin
    tag = '{"R2","R7","R7","R2","R8","R8","R3","R6","R3","R7","R7",
            "R4","R5","R8","R5","R7","R5","R3","R3","R8","R8"};

    // R1 reset state
    #(CLK_PERIOD*2 + 2);
    check("R1", "gnt in reset", ext_gnt_o, 0);
    check("R1", "stall in reset", int_stall_o, 0);
    check_idle_pins("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    #2;
    check("R1", "gnt after reset", ext_gnt_o, 0);
    check_idle_pins("R1");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      mode_i     = VEC[i][6:5];
      ext_req_i  = VEC[i][4];
      int_xfer_i = VEC[i][3];
      int_addr_i = AW'(16'h1000 + i);
      int_data_i = DW'(16'hA500 ^ i);
      #2;
      check(tag[i], $sformatf("show v%0d", i), show_stb_o, VEC[i][2]);
      check(tag[i], $sformatf("gnt v%0d", i), ext_gnt_o, VEC[i][1]);
      check(tag[i], $sformatf("stall v%0d", i), int_stall_o, VEC[i][0]);
      if (VEC[i][2]) begin
        check("R6", $sformatf("oe v%0d", i), {ext_addr_oe_o, ext_data_oe_o}, 2'b11);
        check("R6", $sformatf("addr v%0d", i), ext_addr_o, int_addr_i);
        check("R6", $sformatf("data v%0d", i), ext_data_o, int_data_i);
      end else begin
        check_idle_pins(tag[i]);
      end
    end

    // R1 reset while grant held
    @(negedge clk_i);
    mode_i = 2'b10; ext_req_i = 1'b1; int_xfer_i = 1'b0;
    @(negedge clk_i);
    #2;
    check("R1", "gnt before reset", ext_gnt_o, 1);
    rst_ni = 1'b0;
    #1;
    check("R1", "gnt drops in reset", ext_gnt_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    ext_req_i = 1'b0;
    int_xfer_i = 1'b1;
    int_addr_i = 16'hBEEF;
    int_data_i = 16'h1234;
    #2;
    check("R6", "addr after reset", ext_addr_o, 16'hBEEF);
    check("R1", "gnt after re-reset", ext_gnt_o, 0);

    // R2 quiet mode with transfer and data present
    @(negedge clk_i);
    mode_i = 2'b00;
    #2;
    check_idle_pins("R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*5000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule